// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block produces a card clock from a master clock. The ratio is one of four, chosen by two select inputs: divide by 8, 4 or 2, or a straight pass-through of the master clock. The select inputs may change while the block is running. A new ratio never cuts a pulse short. The changed selection is synchronised first. The block then waits a fixed settling interval and hands over only when the running clock has finished a low phase. The first pulse of the new ratio is therefore a complete high phase.

A flag reports that a change has been seen but not yet applied. Callers can watch this flag to learn when the new frequency is in force. If the selection changes again while a change is pending, the wait restarts and uses the newest value. An intermediate ratio is never emitted.

Top module: `cardclk_div`

## Requirements
- R1: The code {sel_a_i, sel_b_i} picks the ratio: 00 gives divide by 8, 01 divide by 4, 11 divide by 2, and 10 pass-through. In a divided mode each high and each low phase of clk_o lasts half the ratio in master cycles. In pass-through clk_o follows clk_i. Neighbouring codes differ in one bit, and only one select bit may change at a time.
- R2: While rst_ni is low, clk_o and chg_pend_o are low. After release, clk_o stays low until it starts at the ratio given by the select inputs.
- R3: The selects pass through a two-stage synchroniser. chg_pend_o is still low at the second rising edge after a select change and is high at the third.
- R4: A new ratio is not applied before the 12th rising edge after the select change, which is eight master cycles after the change is recognised. It is applied at the first safe boundary from then on, so no later than edge 11 plus the old ratio.
- R5: The hand-over happens only at the end of a low phase. The new ratio starts with a high phase.
- R6: During a change, every phase of clk_o has the full length of either the old ratio or the new ratio. There are no runt pulses.
- R7: chg_pend_o falls at the same rising edge at which the first high phase of the new ratio begins.
- R8: A select change that arrives while a change is pending restarts the eight-cycle wait from the newest value. The abandoned ratio never appears on clk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_a_i | input | 1 | Ratio select, upper code bit (asynchronous) |
| sel_b_i | input | 1 | Ratio select, lower code bit (asynchronous) |
| clk_o | output | 1 | Divided card clock |
| chg_pend_o | output | 1 | A ratio change is recognised but not yet applied |

## Verification
The bench walks every single-bit step of the code ring in both directions, including the steps into and out of pass-through. It records each phase length of clk_o in half master cycles. A design that switched mid-phase would leave a phase matching neither ratio. A design that switched too early would start the new ratio before edge 12, and one that resumed on a low phase would fail the high-start check. Two runs change the selection again while a change is pending: one moves on to a third ratio and one returns to the original. A design that committed to the abandoned value would show phases of the wrong length. After each reset the bench confirms the starting ratio, both in a divided mode and in pass-through.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    typedef logic [1:0] rsel_t;

    // Gray-ordered select codes: neighbours differ in one bit
    localparam rsel_t SEL_DIV8 = 2'b00;
    localparam rsel_t SEL_DIV4 = 2'b01;
    localparam rsel_t SEL_DIV2 = 2'b11;
    localparam rsel_t SEL_BYP  = 2'b10;

    localparam int MAX_DIV = 8;
    localparam int HALF_W  = $clog2(MAX_DIV);

    // Phase length minus one, in master cycles, for the divided modes
    function automatic logic [HALF_W-1:0] half_m1(input rsel_t s);
        logic [HALF_W-1:0] r;
        case (s)
            SEL_DIV8: r = HALF_W'(MAX_DIV / 2 - 1);
            SEL_DIV4: r = HALF_W'(MAX_DIV / 4 - 1);
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic logic is_bypass(input rsel_t s);
        return s == SEL_BYP;
    endfunction

endpackage

// File: rtl/cardclk_sync.sv
module cardclk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q.pipe[STAGES-1];

endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
    import cardclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 8
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  rsel_t sel_i,
    input  logic  boundary_i,
    output logic  apply_o,
    output rsel_t code_o,
    output logic  pend_o,
    output logic  armed_o
);

    localparam int WCNT_W = $clog2(SETTLE_CYC + 1);
    localparam int FILL_W = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic              armed;
        rsel_t             tgt;
        logic              pend;
        logic [WCNT_W-1:0] wcnt;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        apply_o = 1'b0;
        if (!s_q.armed) begin
            // wait for the synchroniser to hold a real sample, then start
            if (s_q.fill == FILL_W'(SYNC_STAGES)) begin
                s_d.armed = 1'b1;
                s_d.tgt   = sel_i;
                apply_o   = 1'b1;
            end else begin
                s_d.fill = s_q.fill + 1'b1;
            end
        end else if (sel_i != s_q.tgt) begin
            // new or newer request: (re)start the settling wait
            s_d.tgt  = sel_i;
            s_d.pend = 1'b1;
            s_d.wcnt = '0;
        end else if (s_q.pend) begin
            if (s_q.wcnt == WCNT_W'(SETTLE_CYC)) begin
                if (boundary_i) begin
                    apply_o  = 1'b1;
                    s_d.pend = 1'b0;
                end
            end else begin
                s_d.wcnt = s_q.wcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign code_o  = s_q.armed ? s_q.tgt : sel_i;
    assign pend_o  = s_q.pend;
    assign armed_o = s_q.armed;

endmodule

// File: rtl/cardclk_phase.sv
module cardclk_phase
    import cardclk_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  apply_i,
    input  rsel_t code_i,
    output logic  boundary_o,
    output logic  div_o,
    output logic  bypass_o
);

    typedef struct packed {
        logic              run;
        logic              bypass;
        logic              div;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] hm1;
    } phase_st_t;

    phase_st_t s_d, s_q;

    // safe hand-over point: a low phase is on its last cycle, or bypass
    assign boundary_o = s_q.run &&
                        (s_q.bypass || (!s_q.div && (s_q.cnt == s_q.hm1)));

    always_comb begin
        s_d = s_q;
        if (apply_i) begin
            s_d.run    = 1'b1;
            s_d.bypass = is_bypass(code_i);
            s_d.div    = !is_bypass(code_i);
            s_d.cnt    = '0;
            s_d.hm1    = half_m1(code_i);
        end else if (s_q.run && !s_q.bypass) begin
            if (s_q.cnt == s_q.hm1) begin
                s_d.div = !s_q.div;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign div_o    = s_q.div;
    assign bypass_o = s_q.bypass;

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_a_i,
    input  logic sel_b_i,
    output logic clk_o,
    output logic chg_pend_o
);

    import cardclk_pkg::*;

    rsel_t sel_sync;
    rsel_t code_w;
    logic  apply_w;
    logic  boundary_w;
    logic  armed_w;
    logic  div_w;
    logic  bypass_w;

    cardclk_sync #(
        .W      ($bits(rsel_t)),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({sel_a_i, sel_b_i}),
        .q_o    (sel_sync)
    );

    cardclk_ctrl #(
        .SYNC_STAGES (SYNC_STAGES),
        .SETTLE_CYC  (SETTLE_CYC)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_i      (sel_sync),
        .boundary_i (boundary_w),
        .apply_o    (apply_w),
        .code_o     (code_w),
        .pend_o     (chg_pend_o),
        .armed_o    (armed_w)
    );

    cardclk_phase u_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .apply_i    (apply_w),
        .code_i     (code_w),
        .boundary_o (boundary_w),
        .div_o      (div_w),
        .bypass_o   (bypass_w)
    );

    // clock multiplexer model: both sources rise together at a hand-over
    assign clk_o = bypass_w ? clk_i : div_w;

endmodule

// File: rtl/cardclk_div_chk.sv
module cardclk_div_chk #(
    parameter int SETTLE_CYC = 8
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] sync_i,
    input logic       pend_i,
    input logic       div_i,
    input logic       bypass_i,
    input logic       armed_i
);

    localparam int AGE_W = $clog2(SETTLE_CYC + 2);

    logic [1:0]       prev_q;
    logic [AGE_W-1:0] age_q;

    // cycles since the synchronised selection last moved
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
            age_q  <= '0;
        end else begin
            prev_q <= sync_i;
            if (sync_i != prev_q)                   age_q <= '0;
            else if (age_q != AGE_W'(SETTLE_CYC + 1)) age_q <= age_q + 1'b1;
        end
    end

    a_r1_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_i && $past(armed_i)) |-> ($countones(sync_i ^ $past(sync_i)) <= 1));

    a_r3_change_flags_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_i && (sync_i != $past(sync_i))) |=> pend_i);

    a_r4_settle_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pend_i) |-> (age_q > AGE_W'(SETTLE_CYC)));

    a_r5_fresh_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pend_i) |-> (div_i || bypass_i));

endmodule

bind cardclk_div cardclk_div_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sel_sync),
    .pend_i   (chg_pend_o),
    .div_i    (div_w),
    .bypass_i (bypass_w),
    .armed_i  (armed_w)
);

// File: tb/sim_cardclk_div.sv
module sim_cardclk_div;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic sa    = 1'b0;
    logic sb    = 1'b0;
    logic clk_o;
    logic pend;

    cardclk_div u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sel_a_i    (sa),
        .sel_b_i    (sb),
        .clk_o      (clk_o),
        .chg_pend_o (pend)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int pc     = 0;
    bit done   = 0;

    // phase log, lengths in half master cycles
    logic ph_lvl [1024];
    int   ph_len [1024];
    int   ph_st  [1024];
    int   nph     = 0;
    logic run_lvl = 1'b0;
    int   run_len = 0;
    int   run_st  = 0;

    task automatic sample();
        if (run_len != 0 && clk_o === run_lvl) begin
            run_len++;
        end else begin
            if (run_len != 0 && nph < 1024) begin
                ph_lvl[nph] = run_lvl;
                ph_len[nph] = run_len;
                ph_st[nph]  = run_st;
                nph++;
            end
            run_lvl = clk_o;
            run_len = 1;
            run_st  = pc;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            pc++;
            #5 sample();
            @(negedge clk);
            #5 sample();
        end
    end

    function automatic int ratio(input logic [1:0] s);
        case (s)
            2'b00:   return 8;
            2'b01:   return 4;
            2'b11:   return 2;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp,
                       input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_sel(input logic [1:0] s);
        sa = s[1];
        sb = s[0];
    endtask

    // wait for the pending flag to drop; returns the edge count then
    task automatic wait_clear(output int pcl);
        pcl = -1;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk);
            #6;
            if (!pend) begin
                pcl = pc;
                break;
            end
        end
        chk(pcl >= 0, "R7", pcl, 0, "pending flag never cleared");
    endtask

    // phases that began after edge c_from: old lengths, then new lengths
    task automatic analyze(input int c_from, input int c_rec, input int lold,
                           input int lnew, input int pcl, input string rtag);
        bit seen_new = 0;
        for (int i = 0; i < nph; i++) begin
            if (ph_st[i] > c_from) begin
                if (!seen_new && lnew != lold && ph_len[i] == lnew) begin
                    seen_new = 1;
                    chk(ph_lvl[i] == 1'b1, "R5", int'(ph_lvl[i]), 1, "first new phase level");
                    chk(ph_st[i] == pcl, "R7", ph_st[i], pcl, "new high start vs pending clear edge");
                    chk(ph_st[i] >= c_rec + 12 && ph_st[i] <= c_rec + 11 + lold, rtag,
                        ph_st[i] - c_rec, 12, "switch edge after change");
                end else if (seen_new) begin
                    chk(ph_len[i] == lnew, "R1", ph_len[i], lnew, "phase length at new ratio");
                end else begin
                    chk(ph_len[i] == lold, "R6", ph_len[i], lold, "phase length before switch");
                end
            end
        end
        if (lnew != lold)
            chk(seen_new, "R4", int'(seen_new), 1, "new ratio observed");
    endtask

    task automatic do_reset(input logic [1:0] s);
        int c;
        int nhigh = 0;
        @(negedge clk);
        #1 rst_n = 1'b0;
        set_sel(s);
        repeat (4) @(negedge clk);
        #2;
        chk(clk_o === 1'b0, "R2", int'(clk_o), 0, "clk_o in reset");
        chk(pend === 1'b0, "R2", int'(pend), 0, "pending in reset");
        rst_n = 1'b1;
        c   = pc;
        nph = 0;
        repeat (40) @(posedge clk);
        #6;
        for (int i = 0; i < nph; i++) begin
            if (ph_st[i] > c) begin
                chk(ph_len[i] == ratio(s), "R2", ph_len[i], ratio(s), "phase length after reset");
                if (ph_lvl[i]) nhigh++;
            end
        end
        chk(nhigh > 0, "R2", nhigh, 1, "high phases after reset");
    endtask

    task automatic transition(input logic [1:0] from, input logic [1:0] to);
        int c;
        int pcl;
        @(negedge clk);
        #1 nph = 0;
        set_sel(to);
        c = pc;
        repeat (2) @(posedge clk);
        #6 chk(pend == 1'b0, "R3", int'(pend), 0, "pending at second edge");
        @(posedge clk);
        #6 chk(pend == 1'b1, "R3", int'(pend), 1, "pending at third edge");
        wait_clear(pcl);
        chk(pcl >= c + 12 && pcl <= c + 11 + ratio(from), "R4", pcl - c, 12,
            "pending clear edge after change");
        repeat (24) @(posedge clk);
        #6 analyze(c, c, ratio(from), ratio(to), pcl, "R4");
    endtask

    // second change while the first is still waiting
    task automatic restart(input logic [1:0] a, input logic [1:0] b, input logic [1:0] cc);
        int c1;
        int c2;
        int pcl;
        @(negedge clk);
        #1 nph = 0;
        set_sel(b);
        c1 = pc;
        repeat (3) @(posedge clk);
        #6 chk(pend == 1'b1, "R3", int'(pend), 1, "pending after first change");
        repeat (3) @(negedge clk);
        #1 set_sel(cc);
        c2 = pc;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #6 chk(pend == 1'b1, "R8", int'(pend), 1, "pending held across restart");
        end
        wait_clear(pcl);
        chk(pcl >= c2 + 12 && pcl <= c2 + 11 + ratio(a), "R8", pcl - c2, 12,
            "clear edge measured from newest change");
        repeat (24) @(posedge clk);
        #6 analyze(c1, c2, ratio(a), ratio(cc), pcl, "R8");
    endtask

    initial begin
        do_reset(2'b00);
        transition(2'b00, 2'b01);
        transition(2'b01, 2'b11);
        transition(2'b11, 2'b10);
        transition(2'b10, 2'b00);
        transition(2'b00, 2'b10);
        transition(2'b10, 2'b11);
        transition(2'b11, 2'b01);
        transition(2'b01, 2'b00);
        restart(2'b00, 2'b01, 2'b11);
        restart(2'b11, 2'b10, 2'b11);
        do_reset(2'b10);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule